// File: doc/BRIEF.md
# Programmable TFT Panel Timing Generator

This block produces the raster timing for a TFT panel. A column counter advances once per pixel clock and a line counter advances each time the column counter wraps. Programmable windows are compared against the two counters to drive horizontal sync, vertical sync and a data-enable window. The same comparison drives a pixel request toward an upstream pixel buffer and four general-purpose panel control strobes.

Every window is one 32-bit word. The start position sits in bits 31:16 and the end position in bits 15:0. A window covers positions that are greater than or equal to start and less than end. For the four control strobes the end may lie beyond the line total, so a strobe can spill into the first columns of the next line. Each strobe has its own polarity bit.

All outputs are registered. A clock-enable input gates the whole block, so one pixel position is consumed per enabled cycle.

Top module: `tft_timing_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, `hsync_o`, `vsync_o`, `de_o`, `pix_req_o` and `frame_start_o` go to 0, each bit of `aux_o` goes to the matching bit of `aux_pol`, and both counters go to 0.
- R2: The column counter counts 0 to H-1, where H is `tot_cfg[31:16]`, and then returns to 0. The line counter advances on every column wrap and counts 0 to V-1, where V is `tot_cfg[15:0]`.
- R3: The outputs after an enabled edge describe the position (column, line) that the counters held before that edge. The first enabled edge after reset therefore presents position (0,0).
- R4: `hsync_o` is 1 exactly when the column lies in the `hsync_cfg` window. `vsync_o` is 1 exactly when the line lies in the `vsync_cfg` window.
- R5: `de_o` is 1 exactly when the column lies in the `hde_cfg` window and the line lies in the `vde_cfg` window. A window whose start is not below its end is empty.
- R6: `pix_req_o` reports the data-enable condition of the position that follows the one presented, so it leads `de_o` by one enabled cycle.
- R7: Strobe i is taken from `aux_win[32*i+31:32*i]`. It is active at column c when c or c+H lies in its window, so an end value above H continues the strobe into columns 0 .. end-H-1 of the following line.
- R8: `aux_o[i]` equals the strobe-i activity XOR `aux_pol[i]`, so a polarity bit of 1 makes that strobe active-low.
- R9: `frame_start_o` is 1 for exactly the one cycle that presents position (0,0).
- R10: While `en` is 0, the counters and every output hold their values. The next enabled edge resumes at the position after the last one presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Pixel-clock enable; advances one position per enabled cycle |
| tot_cfg | input | 32 | Line total H in [31:16], frame total V in [15:0] |
| hsync_cfg | input | 32 | Horizontal sync window (start [31:16], end [15:0]) in columns |
| vsync_cfg | input | 32 | Vertical sync window in lines |
| hde_cfg | input | 32 | Horizontal active window in columns |
| vde_cfg | input | 32 | Vertical active window in lines |
| aux_win | input | 128 | Four strobe windows in columns; strobe i at bits 32*i+31:32*i |
| aux_pol | input | 4 | Per-strobe polarity; 1 inverts strobe i |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high |
| de_o | output | 1 | Data enable |
| pix_req_o | output | 1 | Pixel request, one position ahead of data enable |
| aux_o | output | 4 | Panel control strobes after polarity |
| frame_start_o | output | 1 | One-cycle pulse at position (0,0) |

## Verification
The column wrap and a strobe that crosses the line boundary land in the same cycle. When that wrap is also the last line, the frame-start pulse joins them. One configuration places a strobe window from column 7 to column 13 on a ten-column line, so the strobe must stay high through the wrap into columns 0 to 2, including the cycle where `frame_start_o` pulses. Each cycle is judged against a position model kept in the bench. A freeze of `en` in the middle of a line checks that nothing moves, and that the column after the pause is the one that follows.

// File: rtl/tft_timing_pkg.sv
// Package: shared widths and window type for the TFT timing generator.
// Assumes positions fit in 16 bits; a window word packs start over end.
package tft_timing_pkg;
    localparam int unsigned POS_W   = 16;
    localparam int unsigned WIN_W   = 2 * POS_W;
    localparam int unsigned NUM_AUX = 4;

    typedef struct packed {
        logic [POS_W-1:0] start;
        logic [POS_W-1:0] stop;
    } win_t;
endpackage

// File: rtl/tft_scan_counter.sv
// Module: column and line counters of the raster scan.
// Assumes totals of at least 1; a counter at or past its total minus one wraps,
// so a total lowered on the fly cannot strand a counter above it.
module tft_scan_counter #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] h_total,
    input  logic [W-1:0] v_total,
    output logic [W-1:0] h_q,
    output logic [W-1:0] v_q,
    output logic [W-1:0] h_nx,
    output logic [W-1:0] v_nx
);
    logic h_last;
    logic v_last;

    assign h_last = (h_q >= h_total - W'(1));
    assign v_last = (v_q >= v_total - W'(1));

    // Next position: column steps each enabled cycle, line steps on column wrap.
    always_comb begin
        h_nx = h_q;
        v_nx = v_q;
        if (en) begin
            h_nx = h_last ? '0 : h_q + W'(1);
            if (h_last) begin
                v_nx = v_last ? '0 : v_q + W'(1);
            end
        end
    end

    // Counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_q <= '0;
            v_q <= '0;
        end else begin
            h_q <= h_nx;
            v_q <= v_nx;
        end
    end

    a_r2_col_step: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !h_last) |=> (h_q == $past(h_q) + W'(1)));
    a_r2_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (en && h_last && v_last) |=> (h_q == '0 && v_q == '0));
    a_r10_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(h_q) && $stable(v_q)));
endmodule

// File: rtl/tft_window_cmp.sv
// Module: start/end window comparator against a counter position.
// Active when start <= pos < end. With WRAP set, the position one line later
// (pos + total) is also tested, so a window may run past the total into the
// next line. Assumes total <= 2^W - 1 so the sum fits in W+1 bits.
module tft_window_cmp #(
    parameter int unsigned W    = 16,
    parameter bit          WRAP = 1'b0
) (
    input  logic [W-1:0]   pos,
    input  logic [W-1:0]   total,
    input  logic [2*W-1:0] win,
    output logic           hit
);
    logic [W:0] s_ext;
    logic [W:0] e_ext;
    logic [W:0] p_now;
    logic [W:0] p_late;
    logic       hit_now;
    logic       hit_late;

    assign s_ext  = {1'b0, win[2*W-1:W]};
    assign e_ext  = {1'b0, win[W-1:0]};
    assign p_now  = {1'b0, pos};
    assign p_late = p_now + {1'b0, total};

    // Compare the position in this line and, unfolded, in the previous line's frame.
    always_comb begin
        hit_now  = (p_now  >= s_ext) && (p_now  < e_ext);
        hit_late = (p_late >= s_ext) && (p_late < e_ext);
        hit      = hit_now || (WRAP && hit_late);
    end
endmodule

// File: rtl/tft_timing_gen.sv
// Module: programmable TFT timing generator (top).
// Drives sync, data enable, a one-ahead pixel request, four polarity-selectable
// control strobes and a frame-start pulse from window words compared against
// the scan counters. All outputs are registered and advance only when en is 1.
module tft_timing_gen
    import tft_timing_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic [31:0]              tot_cfg,
    input  logic [31:0]              hsync_cfg,
    input  logic [31:0]              vsync_cfg,
    input  logic [31:0]              hde_cfg,
    input  logic [31:0]              vde_cfg,
    input  logic [NUM_AUX*WIN_W-1:0] aux_win,
    input  logic [NUM_AUX-1:0]       aux_pol,
    output logic                     hsync_o,
    output logic                     vsync_o,
    output logic                     de_o,
    output logic                     pix_req_o,
    output logic [NUM_AUX-1:0]       aux_o,
    output logic                     frame_start_o
);
    win_t             tot_w;
    logic [POS_W-1:0] h_total;
    logic [POS_W-1:0] v_total;
    logic [POS_W-1:0] h_q;
    logic [POS_W-1:0] v_q;
    logic [POS_W-1:0] h_nx;
    logic [POS_W-1:0] v_nx;
    logic             hs_hit;
    logic             vs_hit;
    logic             hde_hit;
    logic             vde_hit;
    logic             hde_nx_hit;
    logic             vde_nx_hit;
    logic [NUM_AUX-1:0] aux_hit;
    win_t             hde_w;

    assign tot_w   = win_t'(tot_cfg);
    assign hde_w   = win_t'(hde_cfg);
    assign h_total = tot_w.start;
    assign v_total = tot_w.stop;

    tft_scan_counter #(.W(POS_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .h_total (h_total),
        .v_total (v_total),
        .h_q     (h_q),
        .v_q     (v_q),
        .h_nx    (h_nx),
        .v_nx    (v_nx)
    );

    tft_window_cmp #(.W(POS_W), .WRAP(1'b0)) u_hs (
        .pos(h_q), .total(h_total), .win(hsync_cfg), .hit(hs_hit));
    tft_window_cmp #(.W(POS_W), .WRAP(1'b0)) u_vs (
        .pos(v_q), .total(v_total), .win(vsync_cfg), .hit(vs_hit));
    tft_window_cmp #(.W(POS_W), .WRAP(1'b0)) u_hde (
        .pos(h_q), .total(h_total), .win(hde_cfg), .hit(hde_hit));
    tft_window_cmp #(.W(POS_W), .WRAP(1'b0)) u_vde (
        .pos(v_q), .total(v_total), .win(vde_cfg), .hit(vde_hit));
    tft_window_cmp #(.W(POS_W), .WRAP(1'b0)) u_hde_nx (
        .pos(h_nx), .total(h_total), .win(hde_cfg), .hit(hde_nx_hit));
    tft_window_cmp #(.W(POS_W), .WRAP(1'b0)) u_vde_nx (
        .pos(v_nx), .total(v_total), .win(vde_cfg), .hit(vde_nx_hit));

    // One wrapping comparator per control strobe.
    for (genvar i = 0; i < NUM_AUX; i++) begin : g_aux
        tft_window_cmp #(.W(POS_W), .WRAP(1'b1)) u_aux (
            .pos   (h_q),
            .total (h_total),
            .win   (aux_win[i*WIN_W +: WIN_W]),
            .hit   (aux_hit[i])
        );
    end

    // Output registers: present the current position, request the next one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hsync_o       <= 1'b0;
            vsync_o       <= 1'b0;
            de_o          <= 1'b0;
            pix_req_o     <= 1'b0;
            frame_start_o <= 1'b0;
            aux_o         <= aux_pol;
        end else if (en) begin
            hsync_o       <= hs_hit;
            vsync_o       <= vs_hit;
            de_o          <= hde_hit && vde_hit;
            pix_req_o     <= hde_nx_hit && vde_nx_hit;
            frame_start_o <= (h_q == '0) && (v_q == '0);
            aux_o         <= aux_hit ^ aux_pol;
        end
    end

    a_r9_frame_origin: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_o |-> ($past(en) && $past(h_q) == '0 && $past(v_q) == '0));
    a_r6_req_leads_de: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && $past(rst_n)) |=> (de_o == $past(pix_req_o)));
    a_r5_empty_window: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && $past(hde_w.start >= hde_w.stop)) |-> !de_o);
    a_r10_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable({hsync_o, vsync_o, de_o, pix_req_o, aux_o, frame_start_o}));
endmodule

// File: tb/tft_timing_gen_tb.sv
// Bench: walks a table of configurations over a full frame each, comparing
// every output against a position model, then directed reset and freeze tests.
module tft_timing_gen_tb;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         en;
    logic [31:0]  tot_cfg, hsync_cfg, vsync_cfg, hde_cfg, vde_cfg;
    logic [127:0] aux_win;
    logic [3:0]   aux_pol;
    logic         hsync_o, vsync_o, de_o, pix_req_o, frame_start_o;
    logic [3:0]   aux_o;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    tft_timing_gen u_dut (
        .clk(clk), .rst_n(rst_n), .en(en),
        .tot_cfg(tot_cfg), .hsync_cfg(hsync_cfg), .vsync_cfg(vsync_cfg),
        .hde_cfg(hde_cfg), .vde_cfg(vde_cfg), .aux_win(aux_win), .aux_pol(aux_pol),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .pix_req_o(pix_req_o),
        .aux_o(aux_o), .frame_start_o(frame_start_o)
    );

    // Layout: tot, hsync, vsync, hde, vde, {aux3,aux2,aux1,aux0}, pol.
    localparam int NCFG = 3;
    localparam logic [291:0] TBL [NCFG] = '{
        {32'h000A_0006, 32'h0000_0002, 32'h0000_0001, 32'h0003_0008, 32'h0002_0005,
         32'h0008_0011, 32'h0001_0002, 32'h0007_000D, 32'h0004_0006, 4'h0},
        {32'h000A_0006, 32'h0001_0003, 32'h0001_0003, 32'h0005_0005, 32'h0000_0006,
         32'h0003_0001, 32'h0000_000A, 32'h0009_000C, 32'h000C_000F, 4'hA},
        {32'h0007_0004, 32'h0000_0001, 32'h0000_0002, 32'h0002_0007, 32'h0001_0004,
         32'h000D_000E, 32'h0003_0003, 32'h0006_0008, 32'h0000_000E, 4'h5}
    };

    function automatic bit inwin(input logic [31:0] w, input int x);
        return (x >= int'(w[31:16])) && (x < int'(w[15:0]));
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Compare all outputs against the model for presented position (h,v).
    task automatic check_pos(input int h, input int v, input bit first);
        int ht, vt, hn, vn;
        logic [3:0] ea;
        ht = int'(tot_cfg[31:16]);
        vt = int'(tot_cfg[15:0]);
        hn = (h == ht - 1) ? 0 : h + 1;
        vn = (h == ht - 1) ? ((v == vt - 1) ? 0 : v + 1) : v;
        for (int i = 0; i < 4; i++)
            ea[i] = (inwin(aux_win[32*i +: 32], h) || inwin(aux_win[32*i +: 32], h + ht)) ^ aux_pol[i];
        chk("R4 sync", {6'd0, vsync_o, hsync_o}, {6'd0, 1'(inwin(vsync_cfg, v)), 1'(inwin(hsync_cfg, h))});
        chk("R5 de", {7'd0, de_o}, {7'd0, 1'(inwin(hde_cfg, h) && inwin(vde_cfg, v))});
        chk("R6 pix_req", {7'd0, pix_req_o}, {7'd0, 1'(inwin(hde_cfg, hn) && inwin(vde_cfg, vn))});
        chk(aux_pol != 0 ? "R8 aux polarity" : "R7 aux window", {4'd0, aux_o}, {4'd0, ea});
        chk(first ? "R3 first position" : "R2/R9 frame start", {7'd0, frame_start_o},
            {7'd0, 1'(h == 0 && v == 0)});
    endtask

    initial begin
        int h, v, ht, vt;
        logic [7:0] snap;
        rst_n = 1'b0;
        en    = 1'b0;
        for (int k = 0; k < NCFG; k++) begin
            @(negedge clk);
            {tot_cfg, hsync_cfg, vsync_cfg, hde_cfg, vde_cfg, aux_win, aux_pol} = TBL[k];
            rst_n = 1'b0;
            en    = 1'b1;
            repeat (2) @(negedge clk);
            // R1: reset state, aux at polarity level.
            chk("R1 reset", {3'd0, frame_start_o, pix_req_o, de_o, vsync_o, hsync_o}, 8'd0);
            chk("R1 reset aux", {4'd0, aux_o}, {4'd0, aux_pol});
            rst_n = 1'b1;
            ht = int'(tot_cfg[31:16]);
            vt = int'(tot_cfg[15:0]);
            h = 0;
            v = 0;
            for (int n = 0; n < ht * vt + 3; n++) begin
                @(negedge clk);
                check_pos(h, v, n == 0);
                if (h == ht - 1) begin
                    h = 0;
                    v = (v == vt - 1) ? 0 : v + 1;
                end else begin
                    h = h + 1;
                end
                if (k == 0 && n == 23) begin
                    // R10: freeze mid-line, outputs must not move.
                    en = 1'b0;
                    snap = {frame_start_o, pix_req_o, de_o, vsync_o, hsync_o, 3'd0};
                    for (int f = 0; f < 3; f++) begin
                        @(negedge clk);
                        chk("R10 hold", {frame_start_o, pix_req_o, de_o, vsync_o, hsync_o, 3'd0}, snap);
                        chk("R10 hold aux", {4'd0, aux_o}, {4'd0, 4'(((inwin(aux_win[31:0], 3) || inwin(aux_win[31:0], 13)) ? 4'h1 : 4'h0)
                            | ((inwin(aux_win[63:32], 3) || inwin(aux_win[63:32], 13)) ? 4'h2 : 4'h0)
                            | ((inwin(aux_win[95:64], 3) || inwin(aux_win[95:64], 13)) ? 4'h4 : 4'h0)
                            | ((inwin(aux_win[127:96], 3) || inwin(aux_win[127:96], 13)) ? 4'h8 : 4'h0))});
                    end
                    en = 1'b1;
                end
            end
        end
        // R1: reset in mid-frame returns to (0,0) on the next enabled edge.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid-frame reset", {3'd0, frame_start_o, pix_req_o, de_o, vsync_o, hsync_o}, 8'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check_pos(0, 0, 1'b1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule